// File: doc/BRIEF.md
# Bidirectional Open-Drain Line Repeater

This block joins a controller-side line and a card-side line, both open-drain with pull-ups, and lets either end start a half-duplex transfer. At rest, nothing drives either side and both lines sit high. The first side to fall becomes the master for the transfer. After a fixed delay, the block pulls the other side (the slave) low so that it copies the level. When the master lets go, the block releases the slave pull-down and drives the slave high for one more delay period, so that the rising edge is fast. Both sides then return to rest.

The block holds `NUM_LINES` identical channels, by default three: one data line and two auxiliary lines. All channels share one enable from the session sequencer. While that enable is low, every channel stays at rest and drives nothing. Each channel reads both of its lines through synchronizers and produces pull-down and pull-up enables for each side. The pad cells carry out the actual drive and level translation.

Top module: `odl_repeater`

## Requirements
- R1: After reset, every pull-down and pull-up enable on every channel is low.
- R2: When the host line of a channel falls while that channel is at rest, its card pull-down enable rises on rising edge DELAY_CYC+3. Edge 1 is the first edge that samples the low level. DELAY_CYC is ceil(CLK_HZ·DELAY_NS/1e9), which is 20 at the defaults.
- R3: When the card line falls while the channel is at rest, the host pull-down enable rises with the same latency as in R2.
- R4: The slave pull-down enable falls on edge 3 after the master line returns high. On that same edge the slave pull-up enable rises. The pull-up stays high for exactly DELAY_CYC cycles, and then all enables of the channel are low.
- R5: While a transfer is in progress, a falling edge on the slave line starts nothing, and the master-side enables stay low. A slave line still held low when the channel returns to rest starts nothing when it is released.
- R6: If both lines of a channel are first seen low in the same sample cycle, the host side becomes master (HOST_WINS_TIE=1).
- R7: If the master line returns high before the slave pull-down has asserted, the transfer is dropped and no enable of that channel asserts.
- R8: When the enable input is low, all enables of all channels are low from the next edge onward, and falling edges seen in that time are ignored. A line that is already low when the enable returns starts no transfer.
- R9: The channels are independent. Transfers on different channels that start together reach the same point on the same edge.
- R10: On any channel, at most one of the four enables is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| lines_en | input | 1 | Sequencer enable; low forces all channels to rest |
| host_in | input | NUM_LINES | Sampled level of each host-side line |
| card_in | input | NUM_LINES | Sampled level of each card-side line |
| host_pd_en | output | NUM_LINES | Host-side pull-down enable per channel |
| host_pu_en | output | NUM_LINES | Host-side active pull-up enable per channel |
| card_pd_en | output | NUM_LINES | Card-side pull-down enable per channel |
| card_pu_en | output | NUM_LINES | Card-side active pull-up enable per channel |

## Verification
Most wrong internal states show up within one delay period as a slave pull-down or pull-up that comes early, late or never. Examples are a wrong master choice, a counter that is off by one, or a missed lockout. A bad edge detector or synchronizer shows up as a shifted assertion edge, or as a transfer started by a level instead of an edge. That is visible at the enable ports on the first cycle where it differs. The bench runs a cycle-exact reference model of every channel and compares all four enables of every channel on every clock. This catches such a shift on the cycle where it first happens.

// File: rtl/odl_rep_pkg.sv
package odl_rep_pkg;

   typedef enum logic [2:0] {
      RS_IDLE   = 3'd0,
      RS_HWAIT  = 3'd1,
      RS_HHOLD  = 3'd2,
      RS_HBOOST = 3'd3,
      RS_CWAIT  = 3'd4,
      RS_CHOLD  = 3'd5,
      RS_CBOOST = 3'd6
   } rep_state_t;

   typedef struct packed {
      logic host_pd;
      logic host_pu;
      logic card_pd;
      logic card_pu;
   } drive_t;

   function automatic int unsigned ns_to_cycles(longint unsigned clk_hz,
                                                longint unsigned dly_ns);
      longint unsigned prod;
      prod = clk_hz * dly_ns;
      return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
   endfunction

endpackage

// File: rtl/odl_sync.sv
module odl_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("odl_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/odl_delay_timer.sv
module odl_delay_timer #(
   parameter int unsigned CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic done
);
   localparam int CNT_W = (CYC > 1) ? $clog2(CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(CYC - 1);

   if (CYC < 1) begin : g_bad_cyc
      $error("odl_delay_timer: CYC must be at least 1");
   end

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (load)       cnt <= LOAD_VAL;
      else if (cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign done = (cnt == '0);

   a_r4_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= LOAD_VAL);

   a_r4_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt == LOAD_VAL));
endmodule

// File: rtl/odl_channel.sv
module odl_channel
   import odl_rep_pkg::*;
#(
   parameter int unsigned DLY_CYC       = 20,
   parameter int          SYNC_STAGES   = 2,
   parameter bit          HOST_WINS_TIE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lines_en,
   input  logic host_in,
   input  logic card_in,
   output logic host_pd,
   output logic host_pu,
   output logic card_pd,
   output logic card_pu
);
   logic host_s, card_s;
   logic host_prev, card_prev;
   logic host_fall, card_fall;
   logic host_take, card_take;
   logic tmr_load, tmr_done;
   rep_state_t st, st_nxt;
   drive_t drv;

   odl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_host (
      .clk(clk), .rst_n(rst_n), .d(host_in), .q(host_s));
   odl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_card (
      .clk(clk), .rst_n(rst_n), .d(card_in), .q(card_s));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         host_prev <= 1'b1;
         card_prev <= 1'b1;
      end else begin
         host_prev <= host_s;
         card_prev <= card_s;
      end
   end

   assign host_fall = host_prev & ~host_s;
   assign card_fall = card_prev & ~card_s;

   if (HOST_WINS_TIE) begin : g_tie_host
      assign host_take = host_fall;
      assign card_take = card_fall & ~host_fall;
   end else begin : g_tie_card
      assign host_take = host_fall & ~card_fall;
      assign card_take = card_fall;
   end

   always_comb begin
      st_nxt   = st;
      tmr_load = 1'b0;
      if (!lines_en) begin
         st_nxt = RS_IDLE;
      end else begin
         unique case (st)
            RS_IDLE: begin
               if (host_take) begin
                  st_nxt = RS_HWAIT; tmr_load = 1'b1;
               end else if (card_take) begin
                  st_nxt = RS_CWAIT; tmr_load = 1'b1;
               end
            end
            RS_HWAIT:  if (host_s) st_nxt = RS_IDLE;
                       else if (tmr_done) st_nxt = RS_HHOLD;
            RS_HHOLD:  if (host_s) begin
                          st_nxt = RS_HBOOST; tmr_load = 1'b1;
                       end
            RS_HBOOST: if (tmr_done) st_nxt = RS_IDLE;
            RS_CWAIT:  if (card_s) st_nxt = RS_IDLE;
                       else if (tmr_done) st_nxt = RS_CHOLD;
            RS_CHOLD:  if (card_s) begin
                          st_nxt = RS_CBOOST; tmr_load = 1'b1;
                       end
            RS_CBOOST: if (tmr_done) st_nxt = RS_IDLE;
            default:   st_nxt = RS_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= RS_IDLE;
      else        st <= st_nxt;
   end

   odl_delay_timer #(.CYC(DLY_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .done(tmr_done));

   always_comb begin
      drv         = '0;
      drv.card_pd = (st == RS_HHOLD);
      drv.card_pu = (st == RS_HBOOST);
      drv.host_pd = (st == RS_CHOLD);
      drv.host_pu = (st == RS_CBOOST);
   end

   assign host_pd = drv.host_pd;
   assign host_pu = drv.host_pu;
   assign card_pd = drv.card_pd;
   assign card_pu = drv.card_pu;

   a_r10_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({host_pd, host_pu, card_pd, card_pu}));

   a_r8_disable_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !lines_en |=> !(host_pd | host_pu | card_pd | card_pu));

   a_r2_copy_host_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_pd) |-> !host_s);

   a_r3_copy_card_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_pd) |-> !card_s);

   a_r4_boost_card_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_pu) |-> $past(card_pd));

   a_r4_boost_host_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(host_pu) |-> $past(host_pd));
endmodule

// File: rtl/odl_repeater.sv
module odl_repeater
   import odl_rep_pkg::*;
#(
   parameter int              NUM_LINES     = 3,
   parameter longint unsigned CLK_HZ        = 100_000_000,
   parameter longint unsigned DELAY_NS      = 200,
   parameter int              SYNC_STAGES   = 2,
   parameter bit              HOST_WINS_TIE = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 lines_en,
   input  logic [NUM_LINES-1:0] host_in,
   input  logic [NUM_LINES-1:0] card_in,
   output logic [NUM_LINES-1:0] host_pd_en,
   output logic [NUM_LINES-1:0] host_pu_en,
   output logic [NUM_LINES-1:0] card_pd_en,
   output logic [NUM_LINES-1:0] card_pu_en
);
   localparam int unsigned DLY_CYC = ns_to_cycles(CLK_HZ, DELAY_NS);

   if (NUM_LINES < 1) begin : g_bad_lines
      $error("odl_repeater: NUM_LINES must be at least 1");
   end
   if (DLY_CYC < 1) begin : g_bad_delay
      $error("odl_repeater: delay rounds to zero cycles");
   end

   for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
      odl_channel #(
         .DLY_CYC      (DLY_CYC),
         .SYNC_STAGES  (SYNC_STAGES),
         .HOST_WINS_TIE(HOST_WINS_TIE)
      ) u_ch (
         .clk     (clk),
         .rst_n   (rst_n),
         .lines_en(lines_en),
         .host_in (host_in[i]),
         .card_in (card_in[i]),
         .host_pd (host_pd_en[i]),
         .host_pu (host_pu_en[i]),
         .card_pd (card_pd_en[i]),
         .card_pu (card_pu_en[i])
      );
   end

   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |-> !(|{host_pd_en, host_pu_en, card_pd_en, card_pu_en}));
endmodule

// File: tb/odl_repeater_tb.sv
module odl_repeater_tb;
   localparam int N = 3;
   localparam int D = 20;  // 100 MHz * 200 ns

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic lines_en = 1'b1;
   logic [N-1:0] ext_h = '0, ext_c = '0;
   logic [N-1:0] host_in, card_in;
   logic [N-1:0] host_pd_en, host_pu_en, card_pd_en, card_pu_en;

   int checks = 0;
   int errors = 0;
   bit done_flag = 0;

   always #5 clk = ~clk;

   assign host_in = ~(ext_h | host_pd_en);
   assign card_in = ~(ext_c | card_pd_en);

   odl_repeater u_dut (
      .clk(clk), .rst_n(rst_n), .lines_en(lines_en),
      .host_in(host_in), .card_in(card_in),
      .host_pd_en(host_pd_en), .host_pu_en(host_pu_en),
      .card_pd_en(card_pd_en), .card_pu_en(card_pu_en));

   // reference model: 0 rest, 1..3 host master (wait, hold, boost), 4..6 card master
   int m_st[N], m_cnt[N];
   bit m_h1[N], m_h2[N], m_hp[N], m_c1[N], m_c2[N], m_cp[N];

   function automatic bit mo_cpd(int i); return m_st[i] == 2; endfunction
   function automatic bit mo_cpu(int i); return m_st[i] == 3; endfunction
   function automatic bit mo_hpd(int i); return m_st[i] == 5; endfunction
   function automatic bit mo_hpu(int i); return m_st[i] == 6; endfunction

   always @(posedge clk or negedge rst_n) begin
      for (int i = 0; i < N; i++) begin
         if (!rst_n) begin
            m_st[i] = 0; m_cnt[i] = 0;
            m_h1[i] = 1; m_h2[i] = 1; m_hp[i] = 1;
            m_c1[i] = 1; m_c2[i] = 1; m_cp[i] = 1;
         end else begin
            bit hin, cin, fh, fc;
            int ns;
            hin = !(ext_h[i] | mo_hpd(i));
            cin = !(ext_c[i] | mo_cpd(i));
            fh = m_hp[i] && !m_h2[i];
            fc = m_cp[i] && !m_c2[i];
            ns = m_st[i];
            if (!lines_en) ns = 0;
            else case (m_st[i])
               0: if (fh) begin ns = 1; m_cnt[i] = D - 1; end
                  else if (fc) begin ns = 4; m_cnt[i] = D - 1; end
               1: if (m_h2[i]) ns = 0; else if (m_cnt[i] == 0) ns = 2; else m_cnt[i]--;
               2: if (m_h2[i]) begin ns = 3; m_cnt[i] = D - 1; end
               3: if (m_cnt[i] == 0) ns = 0; else m_cnt[i]--;
               4: if (m_c2[i]) ns = 0; else if (m_cnt[i] == 0) ns = 5; else m_cnt[i]--;
               5: if (m_c2[i]) begin ns = 6; m_cnt[i] = D - 1; end
               6: if (m_cnt[i] == 0) ns = 0; else m_cnt[i]--;
               default: ns = 0;
            endcase
            m_st[i] = ns;
            m_hp[i] = m_h2[i]; m_h2[i] = m_h1[i]; m_h1[i] = hin;
            m_cp[i] = m_c2[i]; m_c2[i] = m_c1[i]; m_c1[i] = cin;
         end
      end
   end

   task automatic chk(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         for (int i = 0; i < N; i++) begin
            chk(card_pd_en[i] == mo_cpd(i), "R2", $sformatf("model card_pd[%0d]", i), card_pd_en[i], mo_cpd(i));
            chk(host_pd_en[i] == mo_hpd(i), "R3", $sformatf("model host_pd[%0d]", i), host_pd_en[i], mo_hpd(i));
            chk(card_pu_en[i] == mo_cpu(i) && host_pu_en[i] == mo_hpu(i), "R4",
                $sformatf("model pull-ups[%0d]", i), {host_pu_en[i], card_pu_en[i]},
                {mo_hpu(i), mo_cpu(i)});
            chk($onehot0({host_pd_en[i], host_pu_en[i], card_pd_en[i], card_pu_en[i]}), "R10",
                $sformatf("enables[%0d]", i),
                {host_pd_en[i], host_pu_en[i], card_pd_en[i], card_pu_en[i]}, 0);
         end
      end
   end

   task automatic edges(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic finish_run();
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      chk((host_pd_en | host_pu_en | card_pd_en | card_pu_en) == '0, "R1", "outputs in reset",
          host_pd_en | host_pu_en | card_pd_en | card_pu_en, 0);
      rst_n = 1'b1;
      edges(3);
      chk((host_pd_en | host_pu_en | card_pd_en | card_pu_en) == '0, "R1", "outputs after reset",
          host_pd_en | host_pu_en | card_pd_en | card_pu_en, 0);

      // R2 host-initiated transfer on line 0, then R4 release
      ext_h[0] = 1'b1;
      edges(D + 2);
      chk(card_pd_en[0] == 0, "R2", "card_pd before latency", card_pd_en[0], 0);
      edges(1);
      chk(card_pd_en[0] == 1, "R2", "card_pd at latency", card_pd_en[0], 1);
      chk(host_pd_en[0] == 0, "R2", "master side undriven", host_pd_en[0], 0);
      edges(10);
      ext_h[0] = 1'b0;
      edges(2);
      chk(card_pd_en[0] == 1 && card_pu_en[0] == 0, "R4", "hold before release seen",
          {card_pd_en[0], card_pu_en[0]}, 2);
      edges(1);
      chk(card_pd_en[0] == 0 && card_pu_en[0] == 1, "R4", "boost starts",
          {card_pd_en[0], card_pu_en[0]}, 1);
      edges(D - 1);
      chk(card_pu_en[0] == 1, "R4", "boost last cycle", card_pu_en[0], 1);
      edges(1);
      chk(card_pu_en[0] == 0, "R4", "boost ended", card_pu_en[0], 0);
      edges(5);

      // R3 card-initiated transfer on line 1
      ext_c[1] = 1'b1;
      edges(D + 2);
      chk(host_pd_en[1] == 0, "R3", "host_pd before latency", host_pd_en[1], 0);
      edges(1);
      chk(host_pd_en[1] == 1, "R3", "host_pd at latency", host_pd_en[1], 1);
      ext_c[1] = 1'b0;
      edges(3);
      chk(host_pu_en[1] == 1 && host_pd_en[1] == 0, "R4", "host boost starts",
          {host_pd_en[1], host_pu_en[1]}, 1);
      edges(D + 5);

      // R5 lockout on line 2
      ext_h[2] = 1'b1;
      edges(2);
      ext_c[2] = 1'b1;
      edges(D + 4);
      chk(card_pd_en[2] == 1 && host_pd_en[2] == 0, "R5", "slave fall ignored",
          {host_pd_en[2], card_pd_en[2]}, 1);
      ext_h[2] = 1'b0;
      edges(3);
      chk(card_pu_en[2] == 1 && host_pd_en[2] == 0, "R5", "boost with slave held",
          {host_pd_en[2], card_pu_en[2]}, 1);
      edges(D + 2);
      ext_c[2] = 1'b0;
      edges(30);
      chk({host_pd_en[2], host_pu_en[2], card_pd_en[2], card_pu_en[2]} == 0, "R5",
          "no transfer after slave release",
          {host_pd_en[2], host_pu_en[2], card_pd_en[2], card_pu_en[2]}, 0);

      // R6 simultaneous fall on line 0
      ext_h[0] = 1'b1; ext_c[0] = 1'b1;
      edges(D + 3);
      chk(card_pd_en[0] == 1 && host_pd_en[0] == 0, "R6", "host wins tie",
          {host_pd_en[0], card_pd_en[0]}, 1);
      ext_h[0] = 1'b0; ext_c[0] = 1'b0;
      edges(D + 10);

      // R7 short master pulse dropped
      ext_h[1] = 1'b1;
      edges(5);
      ext_h[1] = 1'b0;
      for (int k = 0; k < D + 10; k++) begin
         edges(1);
         chk(card_pd_en[1] == 0 && card_pu_en[1] == 0, "R7", "short pulse not copied",
             {card_pd_en[1], card_pu_en[1]}, 0);
      end

      // R8 disable during hold, ignore edges while disabled, no stale start
      ext_h[0] = 1'b1;
      edges(D + 3);
      chk(card_pd_en[0] == 1, "R8", "hold before disable", card_pd_en[0], 1);
      lines_en = 1'b0;
      edges(1);
      chk((host_pd_en | host_pu_en | card_pd_en | card_pu_en) == '0, "R8", "all off when disabled",
          host_pd_en | host_pu_en | card_pd_en | card_pu_en, 0);
      ext_h[0] = 1'b0;
      edges(5);
      ext_c[0] = 1'b1;
      edges(D + 5);
      chk(host_pd_en[0] == 0, "R8", "fall ignored while disabled", host_pd_en[0], 0);
      lines_en = 1'b1;
      edges(D + 5);
      chk(host_pd_en[0] == 0, "R8", "held level starts nothing", host_pd_en[0], 0);
      ext_c[0] = 1'b0;
      edges(10);

      // R9 independent channels
      ext_h[0] = 1'b1; ext_c[1] = 1'b1;
      edges(D + 3);
      chk(card_pd_en[0] == 1 && host_pd_en[1] == 1, "R9", "two channels same edge",
          {card_pd_en[0], host_pd_en[1]}, 3);
      chk({host_pd_en[2], host_pu_en[2], card_pd_en[2], card_pu_en[2]} == 0, "R9",
          "idle channel untouched",
          {host_pd_en[2], host_pu_en[2], card_pd_en[2], card_pu_en[2]}, 0);
      ext_h[0] = 1'b0; ext_c[1] = 1'b0;
      edges(D + 10);

      finish_run();
   end
endmodule